// File: doc/BRIEF.md
# TDM Channel Word Serializer/Deserializer

This block exchanges one 8-bit word per frame with a time-division serial highway. A transfer window opens while both the active-low frame strobe `frame_n` and the active-low slot select `chan_n` are low. During that window the block drives one transmit bit per bit clock, most significant bit first, and samples one receive bit per bit clock from the incoming line. Receive and transmit share the same window. Outside the window the serial output driver is switched off (`ser_oe` low).

Transmit words come in on a valid/ready port. The block holds one pending word. `tx_ready` is high while that holding slot is empty. A word is taken on any rising edge with `tx_valid` and `tx_ready` both high. The upstream side must keep `tx_data` steady while it waits for ready. The pending word is copied into the shift register when a window opens, which frees the holding slot for the next frame. The receive side has no back-pressure, because the line cannot be stalled. A received byte appears on `rx_data` with a one-cycle `rx_valid` strobe after the window closes. A window that closes before eight bits have been exchanged raises a one-cycle `slot_err` instead.

Top module: `tdm_slot_serdes`

## Requirements
- R1: A word is accepted when `tx_valid` and `tx_ready` are both high at a rising edge. `tx_ready` then stays low until the next window opens and takes the word.
- R2: `ser_oe` is high only while `frame_n` and `chan_n` are both low, and only for the first 8 bit clocks of such a window.
- R3: Transmit is MSB first, one bit per clock. The first driven cycle of a window carries bit 7 of the word, and each following rising edge advances one bit.
- R4: The word sent in a window is the one that was pending when the window opened. A word accepted while the window is running goes out in the next window.
- R5: If no word is pending when a window opens, the idle word 8'hFF is sent.
- R6: `ser_in` is sampled on the falling edge of each of the first 8 window clocks. The first sampled bit becomes `rx_data[7]` and the last becomes `rx_data[0]`.
- R7: After a window of at least 8 clocks closes, `rx_valid` is high for exactly one clock, in the cycle after the first cycle with an enable high, and `rx_data` carries the byte.
- R8: A window of 1 to 7 clocks produces a one-cycle `slot_err` in that same position instead of `rx_valid`, and `rx_data` keeps its previous value.
- R9: In a window longer than 8 clocks, the extra clocks leave `ser_oe` low and their `ser_in` bits are ignored.
- R10: After reset, `ser_oe`, `rx_valid` and `slot_err` are low and `tx_ready` is high.
- R11: `rx_data` holds its value between `rx_valid` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one serial bit per period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe |
| chan_n | input | 1 | Active-low channel slot select |
| tx_data | input | 8 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| ser_oe | output | 1 | Serial output driver enable (three-state control) |
| ser_dat | output | 1 | Serial output bit, meaningful when `ser_oe` is high |
| ser_in | input | 1 | Incoming serial line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| slot_err | output | 1 | One-cycle strobe for a window that was too short |

## Verification
Transmit and receive words with alternating, asymmetric and single-bit patterns (A5/3C, 5A/81, 96) catch bit reversal, off-by-one shifting and a swapped first or last bit. A write made in the middle of a window separates a holding register that is latched at window start from one that leaks through. Windows of 5, 8 and 11 clocks, and a window with only one enable low, test whether the length and enable decoding drives the error strobe, the valid strobe and the driver enable correctly. A window with no pending word checks the idle fill.

// File: rtl/tdm_serdes_pkg.sv
package tdm_serdes_pkg;

  // Per-cycle slot events shared by the transmit and receive paths.
  typedef struct packed {
    logic first;  // first clock of an open window
    logic shift;  // window open and bit budget not used up
    logic close;  // window just closed
    logic full;   // all word bits exchanged in this window
  } slot_ev_t;

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import tdm_serdes_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_n,
  input  logic     chan_n,
  output slot_ev_t ev
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [CNT_W-1:0] bit_cnt;
  logic             win;
  logic             win_q;

  assign win = ~frame_n & ~chan_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      win_q   <= 1'b0;
    end else begin
      win_q <= win;
      if (!win)
        bit_cnt <= '0;
      else if (bit_cnt < CNT_MAX)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_comb begin
    ev.first = win && (bit_cnt == '0);
    ev.shift = win && (bit_cnt < CNT_MAX);
    ev.close = win_q && !win;
    ev.full  = (bit_cnt == CNT_MAX);
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_MAX);

endmodule

// File: rtl/tx_path.sv
module tx_path
  import tdm_serdes_pkg::*;
#(
  parameter int              WORD_W = 8,
  parameter logic [WORD_W-1:0] IDLE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ev_t          ev,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              ser_dat
);
  logic [WORD_W-1:0] pend;
  logic              pend_v;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] load_w;
  logic              accept;

  assign tx_ready = ~pend_v;
  assign accept   = tx_valid & ~pend_v;
  assign load_w   = pend_v ? pend : IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      pend_v <= 1'b0;
      shreg  <= '0;
    end else begin
      if (ev.first)
        pend_v <= 1'b0;
      if (accept) begin
        pend_v <= 1'b1;
        pend   <= tx_data;
      end
      if (ev.first)
        shreg <= {load_w[WORD_W-2:0], 1'b0};
      else if (ev.shift)
        shreg <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

  always_comb begin
    if (ev.first)
      ser_dat = load_w[WORD_W-1];
    else if (ev.shift)
      ser_dat = shreg[WORD_W-1];
    else
      ser_dat = 1'b0;
  end

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !ev.first) |=> $stable(pend));

endmodule

// File: rtl/rx_path.sv
module rx_path
  import tdm_serdes_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ev_t          ev,
  input  logic              ser_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              slot_err
);
  logic              neg_bit;
  logic [WORD_W-1:0] shreg;

  // Line sampled mid-bit on the falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_bit <= 1'b0;
    else        neg_bit <= ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      slot_err <= 1'b0;
    end else begin
      if (ev.shift)
        shreg <= {shreg[WORD_W-2:0], neg_bit};
      rx_valid <= ev.close & ev.full;
      slot_err <= ev.close & ~ev.full;
      if (ev.close && ev.full)
        rx_data <= shreg;
    end
  end

  // R7
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && slot_err));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

endmodule

// File: rtl/tdm_slot_serdes.sv
module tdm_slot_serdes
  import tdm_serdes_pkg::*;
#(
  parameter int                WORD_W = 8,
  parameter logic [WORD_W-1:0] IDLE   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              chan_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              ser_oe,
  output logic              ser_dat,
  input  logic              ser_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              slot_err
);
  slot_ev_t ev;

  slot_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .chan_n(chan_n), .ev(ev)
  );

  tx_path #(.WORD_W(WORD_W), .IDLE(IDLE)) tx_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .ser_dat(ser_dat)
  );

  rx_path #(.WORD_W(WORD_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ser_in(ser_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .slot_err(slot_err)
  );

  assign ser_oe = ev.shift;

  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe |-> (!frame_n && !chan_n));

endmodule

// File: tb/tdm_slot_serdes_tb_top.sv
module tdm_slot_serdes_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic       chan_n = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       ser_oe;
  logic       ser_dat;
  logic       ser_in = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       slot_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tdm_slot_serdes dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .chan_n(chan_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ser_oe(ser_oe), .ser_dat(ser_dat), .ser_in(ser_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .slot_err(slot_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive point: 1 ns after a rising edge. Outputs are sampled 2 ns later.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] w);
    tick();
    tx_valid = 1'b1;
    tx_data  = w;
    #2 chk(tx_ready == 1'b1, "R1 ready before push", tx_ready, 1);
    tick();
    tx_valid = 1'b0;
    #2 chk(tx_ready == 1'b0, "R1 ready low after accept", tx_ready, 0);
  endtask

  // Runs a window of len clocks. Ends at the sample point of the strobe cycle.
  task automatic do_slot(input int len, input logic [7:0] rxw, input bit mid_push,
                         input logic [7:0] mid_w, output logic [7:0] seen,
                         output bit oe_ok, output bit extra_ok);
    seen = '0;
    oe_ok = 1;
    extra_ok = 1;
    for (int i = 0; i < len; i++) begin
      tick();
      frame_n = 1'b0;
      chan_n  = 1'b0;
      ser_in  = (i < 8) ? rxw[7-i] : ~rxw[0];
      if (mid_push && i == 2) begin tx_valid = 1'b1; tx_data = mid_w; end
      if (mid_push && i == 3) tx_valid = 1'b0;
      #2;
      if (i < 8) begin
        seen[7-i] = ser_dat;
        if (!ser_oe) oe_ok = 0;
      end else if (ser_oe) extra_ok = 0;
    end
    tick();
    frame_n = 1'b1;
    chan_n  = 1'b1;
    ser_in  = 1'b0;
    tick();
    #2;
  endtask

  task automatic t_reset();
    chk(ser_oe == 1'b0, "R10 oe", ser_oe, 0);
    chk(tx_ready == 1'b1, "R10 ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R10 valid", rx_valid, 0);
    chk(slot_err == 1'b0, "R10 err", slot_err, 0);
  endtask

  task automatic t_basic();
    logic [7:0] s; bit o, e;
    push(8'hA5);
    do_slot(8, 8'h3C, 0, 8'h00, s, o, e);
    chk(s == 8'hA5, "R3 msb-first tx", s, 8'hA5);
    chk(o, "R2 oe during window", o, 1);
    chk(rx_valid == 1'b1, "R7 valid strobe", rx_valid, 1);
    chk(rx_data == 8'h3C, "R6 rx byte", rx_data, 8'h3C);
    chk(tx_ready == 1'b1, "R1 ready after window", tx_ready, 1);
    tick(); #2;
    chk(rx_valid == 1'b0, "R7 strobe one cycle", rx_valid, 0);
    chk(ser_oe == 1'b0, "R2 oe off after window", ser_oe, 0);
  endtask

  task automatic t_holding();
    logic [7:0] s; bit o, e;
    push(8'h5A);
    do_slot(8, 8'h81, 1, 8'hC3, s, o, e);
    chk(s == 8'h5A, "R4 latched word", s, 8'h5A);
    chk(rx_data == 8'h81, "R6 rx edge bits", rx_data, 8'h81);
    chk(tx_ready == 1'b0, "R4 mid-window word pending", tx_ready, 0);
    do_slot(8, 8'h00, 0, 8'h00, s, o, e);
    chk(s == 8'hC3, "R4 next window word", s, 8'hC3);
  endtask

  task automatic t_underrun();
    logic [7:0] s; bit o, e;
    do_slot(8, 8'h11, 0, 8'h00, s, o, e);
    chk(s == 8'hFF, "R5 idle fill", s, 8'hFF);
  endtask

  task automatic t_short();
    logic [7:0] s; bit o, e;
    logic [7:0] prev;
    prev = rx_data;
    push(8'h0F);
    do_slot(5, 8'hE7, 0, 8'h00, s, o, e);
    chk(slot_err == 1'b1, "R8 err strobe", slot_err, 1);
    chk(rx_valid == 1'b0, "R8 no valid", rx_valid, 0);
    chk(rx_data == prev, "R8 data kept", rx_data, prev);
    tick(); #2;
    chk(slot_err == 1'b0, "R8 err one cycle", slot_err, 0);
  endtask

  task automatic t_long();
    logic [7:0] s; bit o, e;
    push(8'h69);
    do_slot(11, 8'h96, 0, 8'h00, s, o, e);
    chk(s == 8'h69, "R3 tx long window", s, 8'h69);
    chk(e, "R9 oe off past 8 bits", e, 1);
    chk(rx_valid == 1'b1 && rx_data == 8'h96, "R9 extra bits ignored", rx_data, 8'h96);
  endtask

  task automatic t_one_enable();
    bit bad = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      frame_n = 1'b0;
      chan_n  = (i < 2);
      frame_n = (i >= 2);
      #2 if (ser_oe) bad = 1;
    end
    tick(); frame_n = 1'b1; chan_n = 1'b1;
    chk(!bad, "R2 single enable no drive", bad, 0);
    tick(); #2;
    chk(!rx_valid && !slot_err, "R2 no strobe", {rx_valid, slot_err}, 0);
  endtask

  task automatic t_hold();
    logic [7:0] prev;
    prev = rx_data;
    for (int i = 0; i < 5; i++) tick();
    #2 chk(rx_data == prev, "R11 data held", rx_data, prev);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1'b1;
    #2 t_reset();
    t_basic();
    t_holding();
    t_underrun();
    t_short();
    t_long();
    t_one_enable();
    t_hold();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule